// File: doc/BRIEF.md
# Dual-strobe up/down counter

A small synchronous counter whose value is moved by two separate count strobes, one per direction, instead of by a clock and a direction bit. Each strobe idles high. A low-to-high transition on the up strobe adds one to the count, provided the down strobe is being held high. A transition on the down strobe subtracts one, provided the up strobe is held high. An elaboration parameter makes the counter either a decade (0 to 9) counter or a plain binary (0 to 15) counter. It also has an active-low parallel preset, an active-high clear, and two active-low terminal-count outputs.

The whole block runs on one system clock. Each strobe goes through a two-flop synchroniser, and its rising edge is found by comparing the synchronised level with a delayed copy. The count therefore changes on the third system-clock edge after a strobe rises. The carry output is low while the count sits at its maximum and the delayed up-strobe level is low. The borrow output is low while the count is zero and the delayed down-strobe level is low. Both outputs rise on the same clock edge on which the count wraps.

Because of this timing, a wider counter is built by wiring carry to the next stage's up strobe and borrow to the next stage's down strobe, with no other logic. All pins are plain control and data pins. There is no valid/ready stream and no back-pressure.

Top module: `dual_strobe_counter`

## Requirements
- R1: While `clr` is 1 at a clock edge, `q` becomes 0 on that edge. This overrides `load_n`, `din` and both strobes.
- R2: While `load_n` is 0 and `clr` is 0, `q` takes `din` on each clock edge. A strobe edge seen during that time is discarded and causes no later count.
- R3: A rising edge on `cnt_up` while `cnt_dn` is held high increments `q`. The new value appears on the third clock edge after the rise.
- R4: A rising edge on `cnt_dn` while `cnt_up` is held high decrements `q`, with the same three-edge latency.
- R5: The count wraps at MAX, where MAX is 9 with DECADE=1 and 15 with DECADE=0. Counting up from MAX gives 0, and counting down from 0 gives MAX.
- R6: With DECADE=1, a preset value from 10 to 15 counts up by one and goes from 15 to 0. Counting down from such a value simply decrements it.
- R7: `carry_n` is 0 while `q` equals MAX and the up strobe, as seen three edges late, is low. It returns to 1 on the same edge on which `q` wraps to 0.
- R8: `borrow_n` is 0 while `q` is 0 and the down strobe, as seen three edges late, is low. It returns to 1 on the same edge on which `q` wraps to MAX.
- R9: `q` does not change in two cases: both strobes rise on the same edge, or one strobe rises while the other is low.
- R10: Two counters chained carry-to-up and borrow-to-down behave as one two-digit counter. The upper stage steps after the lower stage wraps.
- R11: While `rst_n` is 0, `q` is 0 and `carry_n` and `borrow_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Clear to zero, active high, highest priority |
| load_n | input | 1 | Parallel preset from `din`, active low |
| din | input | WIDTH | Preset value |
| cnt_up | input | 1 | Up-count strobe, idles high, acts on its rising edge |
| cnt_dn | input | 1 | Down-count strobe, idles high, acts on its rising edge |
| q | output | WIDTH | Current count |
| carry_n | output | 1 | Terminal count while counting up, active low |
| borrow_n | output | 1 | Terminal count while counting down, active low |

## Verification
A decade counter and a binary counter are driven with the same sequence of clears, presets and single-strobe pulses.
- The presets of 7, 13 and 12 put the two modes on different paths: one wraps after 9 and the other after 15, and a decade counter started above 9 behaves differently from a binary one.
- Holding a strobe low and then releasing it shows whether the terminal outputs fall and rise on the right edges.
- Raising both strobes together, or raising one while the other is held low, separates a counter that qualifies its strobes from one that counts on any edge.
- A two-stage chain checks that the carry and borrow timing is enough to ripple into a second stage.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  typedef enum logic [2:0] {
    ST_HOLD,
    ST_UP,
    ST_DN,
    ST_LOAD,
    ST_CLR
  } step_e;
endpackage

// File: rtl/dsc_strobe_sync.sv
// Synchroniser chain for one count strobe, plus a delayed copy for edge finding.
module dsc_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_i,
  output logic level_o,
  output logic held_o,
  output logic rise_o
);
  logic [STAGES-1:0] chain_q;
  logic              held_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b1;
        else        chain_q[i] <= strobe_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[i] <= 1'b1;
        else        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= 1'b1;
    else        held_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign held_o  = held_q;
  assign rise_o  = chain_q[STAGES-1] & ~held_q;
endmodule

// File: rtl/dsc_step_arbiter.sv
// Picks one action per clock: clear, then preset, then a qualified count.
module dsc_step_arbiter
  import dsc_pkg::*;
(
  input  logic  clr,
  input  logic  load_n,
  input  logic  up_rise,
  input  logic  up_level,
  input  logic  dn_rise,
  input  logic  dn_level,
  output step_e step
);
  always_comb begin
    if (clr)                                   step = ST_CLR;
    else if (!load_n)                          step = ST_LOAD;
    else if (up_rise && !dn_rise && dn_level)  step = ST_UP;
    else if (dn_rise && !up_rise && up_level)  step = ST_DN;
    else                                       step = ST_HOLD;
  end
endmodule

// File: rtl/dsc_next_value.sv
// Next count for the chosen action; the wrap rule depends on DECADE.
module dsc_next_value
  import dsc_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input  step_e            step,
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] nxt
);
  localparam int               MAXI = DECADE ? 9 : (2**WIDTH) - 1;
  localparam logic [WIDTH-1:0] MAXV = MAXI[WIDTH-1:0];
  localparam logic [WIDTH-1:0] ALL1 = '1;

  logic [WIDTH-1:0] up_val;
  logic [WIDTH-1:0] dn_val;

  if (DECADE) begin : g_decade
    // codes above MAX keep climbing and fold to zero after the all-ones code
    assign up_val = (cur == MAXV || cur == ALL1) ? '0 : cur + 1'b1;
    assign dn_val = (cur == '0) ? MAXV : cur - 1'b1;
  end else begin : g_binary
    assign up_val = cur + 1'b1;
    assign dn_val = cur - 1'b1;
  end

  always_comb begin
    case (step)
      ST_CLR:  nxt = '0;
      ST_LOAD: nxt = din;
      ST_UP:   nxt = up_val;
      ST_DN:   nxt = dn_val;
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/dual_strobe_counter.sv
module dual_strobe_counter
  import dsc_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter bit DECADE      = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             load_n,
  input  logic [WIDTH-1:0] din,
  input  logic             cnt_up,
  input  logic             cnt_dn,
  output logic [WIDTH-1:0] q,
  output logic             carry_n,
  output logic             borrow_n
);
  localparam int               MAXI = DECADE ? 9 : (2**WIDTH) - 1;
  localparam logic [WIDTH-1:0] MAXV = MAXI[WIDTH-1:0];

  logic             up_level, up_held, up_rise;
  logic             dn_level, dn_held, dn_rise;
  step_e            step;
  logic [WIDTH-1:0] q_r, q_next;

  dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk(clk), .rst_n(rst_n), .strobe_i(cnt_up),
    .level_o(up_level), .held_o(up_held), .rise_o(up_rise)
  );

  dsc_strobe_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk(clk), .rst_n(rst_n), .strobe_i(cnt_dn),
    .level_o(dn_level), .held_o(dn_held), .rise_o(dn_rise)
  );

  dsc_step_arbiter u_arb (
    .clr(clr), .load_n(load_n),
    .up_rise(up_rise), .up_level(up_level),
    .dn_rise(dn_rise), .dn_level(dn_level),
    .step(step)
  );

  dsc_next_value #(.WIDTH(WIDTH), .DECADE(DECADE)) u_next (
    .step(step), .cur(q_r), .din(din), .nxt(q_next)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_next;
  end

  assign q = q_r;
  // the held copy changes on the same edge as the count, so the terminal
  // outputs rise exactly when the wrap lands
  assign carry_n  = ~((q_r == MAXV) & ~up_held);
  assign borrow_n = ~((q_r == '0)   & ~dn_held);
endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             load_n,
  input logic [WIDTH-1:0] din,
  input logic [WIDTH-1:0] q,
  input logic             carry_n,
  input logic             borrow_n,
  input logic             up_rise,
  input logic             up_level,
  input logic             dn_rise,
  input logic             dn_level
);
  localparam int               MAXI = DECADE ? 9 : (2**WIDTH) - 1;
  localparam logic [WIDTH-1:0] MAXV = MAXI[WIDTH-1:0];
  localparam logic [WIDTH-1:0] ALL1 = '1;

  logic go_up, go_dn;
  assign go_up = !clr && load_n && up_rise && !dn_rise && dn_level;
  assign go_dn = !clr && load_n && dn_rise && !up_rise && up_level;

  a_r1_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (q == '0));

  a_r2_preset: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !load_n) |=> (q == $past(din)));

  a_r3_up_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go_up && q != MAXV && q != ALL1) |=> (q == $past(q) + 1'b1));

  a_r4_dn_step: assert property (@(posedge clk) disable iff (!rst_n)
    (go_dn && q != '0) |=> (q == $past(q) - 1'b1));

  a_r5_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (go_up && q == MAXV) |=> (q == '0));

  a_r5_wrap_dn: assert property (@(posedge clk) disable iff (!rst_n)
    (go_dn && q == '0) |=> (q == MAXV));

  a_r7_carry_at_max: assert property (@(posedge clk) disable iff (!rst_n)
    !carry_n |-> (q == MAXV));

  a_r7_carry_rise_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry_n) |-> (q == '0 || $past(clr) || !$past(load_n)));

  a_r8_borrow_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !borrow_n |-> (q == '0));

  a_r8_borrow_rise_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(borrow_n) |-> (q == MAXV || $past(clr) || !$past(load_n)));

  a_r9_both_rise_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && up_rise && dn_rise) |=> $stable(q));

  a_r9_other_low_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && load_n && ((up_rise && !dn_level) || (dn_rise && !up_level)))
      |=> $stable(q));

  if (DECADE) begin : g_dec_chk
    a_r6_stays_decimal: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr && load_n && q <= MAXV) |=> (q <= MAXV));
  end
endmodule

bind dual_strobe_counter dsc_checker #(.WIDTH(WIDTH), .DECADE(DECADE)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din), .q(q),
  .carry_n(carry_n), .borrow_n(borrow_n), .up_rise(up_rise),
  .up_level(up_level), .dn_rise(dn_rise), .dn_level(dn_level)
);

// File: tb/dual_strobe_counter_bench.sv
module dual_strobe_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr = 1'b0;
  logic       load_n = 1'b1;
  logic [3:0] din = 4'd0;
  logic       cnt_up = 1'b1;
  logic       cnt_dn = 1'b1;
  logic [3:0] q_dec, q_bin, q_lo, q_hi;
  logic       cy_dec, bw_dec, cy_bin, bw_bin, cy_lo, bw_lo, cy_hi, bw_hi;
  int         n_checks = 0;
  int         n_fail   = 0;

  always #4 clk = ~clk;

  dual_strobe_counter u_dual_strobe_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .q(q_dec), .carry_n(cy_dec), .borrow_n(bw_dec));

  dual_strobe_counter #(.DECADE(1'b0)) u_dual_strobe_counter_bin (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .q(q_bin), .carry_n(cy_bin), .borrow_n(bw_bin));

  dual_strobe_counter u_casc_lo (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
    .cnt_up(cnt_up), .cnt_dn(cnt_dn), .q(q_lo), .carry_n(cy_lo), .borrow_n(bw_lo));

  dual_strobe_counter u_casc_hi (
    .clk(clk), .rst_n(rst_n), .clr(clr), .load_n(load_n), .din(din),
    .cnt_up(cy_lo), .cnt_dn(bw_lo), .q(q_hi), .carry_n(cy_hi), .borrow_n(bw_hi));

  // op[13:12] (0 clear, 1 preset, 2 up, 3 down), data[11:8], decade[7:4], binary[3:0]
  localparam logic [13:0] VEC [0:18] = '{
    {2'd0, 4'd0,  4'd0,  4'd0 }, {2'd1, 4'd7,  4'd7,  4'd7 },
    {2'd2, 4'd0,  4'd8,  4'd8 }, {2'd2, 4'd0,  4'd9,  4'd9 },
    {2'd2, 4'd0,  4'd0,  4'd10}, {2'd2, 4'd0,  4'd1,  4'd11},
    {2'd3, 4'd0,  4'd0,  4'd10}, {2'd3, 4'd0,  4'd9,  4'd9 },
    {2'd3, 4'd0,  4'd8,  4'd8 }, {2'd1, 4'd13, 4'd13, 4'd13},
    {2'd2, 4'd0,  4'd14, 4'd14}, {2'd2, 4'd0,  4'd15, 4'd15},
    {2'd2, 4'd0,  4'd0,  4'd0 }, {2'd3, 4'd0,  4'd9,  4'd15},
    {2'd3, 4'd0,  4'd8,  4'd14}, {2'd1, 4'd12, 4'd12, 4'd12},
    {2'd3, 4'd0,  4'd11, 4'd11}, {2'd0, 4'd0,  4'd0,  4'd0 },
    {2'd3, 4'd0,  4'd9,  4'd15}
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_neg(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_clear();
    clr = 1'b1; wait_neg(1); clr = 1'b0; wait_neg(1);
  endtask

  task automatic do_load(input logic [3:0] d);
    din = d; load_n = 1'b0; wait_neg(1); load_n = 1'b1; wait_neg(1);
  endtask

  task automatic pulse_up();
    cnt_up = 1'b0; wait_neg(3); cnt_up = 1'b1; wait_neg(3);
  endtask

  task automatic pulse_dn();
    cnt_dn = 1'b0; wait_neg(3); cnt_dn = 1'b1; wait_neg(3);
  endtask

  initial begin
    #(8 * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    wait_neg(2);
    // R11 reset state
    chk("R11 q in reset", q_dec, 0);
    chk("R11 carry_n in reset", cy_dec, 1);
    chk("R11 borrow_n in reset", bw_dec, 1);
    rst_n = 1'b1;
    wait_neg(2);

    // table walk, R1 R2 R3 R4 R5 R6 against both modes
    for (int k = 0; k < 19; k++) begin
      case (VEC[k][13:12])
        2'd0: do_clear();
        2'd1: do_load(VEC[k][11:8]);
        2'd2: pulse_up();
        default: pulse_dn();
      endcase
      chk($sformatf("R5 R6 vector %0d decade q", k), q_dec, int'(VEC[k][7:4]));
      chk($sformatf("R5 vector %0d binary q", k), q_bin, int'(VEC[k][3:0]));
    end

    // R7 carry timing at 9 on the decade counter
    do_load(4'd9);
    cnt_up = 1'b0; wait_neg(3);
    chk("R7 decade carry_n low at max", cy_dec, 0);
    chk("R7 binary carry_n high below max", cy_bin, 1);
    cnt_up = 1'b1; wait_neg(2);
    chk("R3 count not yet moved", q_dec, 9);
    chk("R7 carry_n still low before wrap", cy_dec, 0);
    wait_neg(1);
    chk("R7 decade wrap to 0", q_dec, 0);
    chk("R7 carry_n back high with wrap", cy_dec, 1);
    chk("R3 binary 9 to 10", q_bin, 10);

    // R7 at 15: binary terminal, decade illegal code (R6)
    do_load(4'd15);
    cnt_up = 1'b0; wait_neg(3);
    chk("R7 binary carry_n low at 15", cy_bin, 0);
    chk("R6 decade carry_n high at 15", cy_dec, 1);
    cnt_up = 1'b1; wait_neg(3);
    chk("R5 binary 15 to 0", q_bin, 0);
    chk("R6 decade 15 to 0", q_dec, 0);

    // R8 borrow timing
    do_clear();
    cnt_dn = 1'b0; wait_neg(3);
    chk("R8 decade borrow_n low at 0", bw_dec, 0);
    chk("R8 binary borrow_n low at 0", bw_bin, 0);
    cnt_dn = 1'b1; wait_neg(2);
    chk("R8 borrow_n still low before wrap", bw_dec, 0);
    wait_neg(1);
    chk("R8 decade wrap to 9", q_dec, 9);
    chk("R8 binary wrap to 15", q_bin, 15);
    chk("R8 borrow_n high with wrap", bw_dec, 1);

    // R2 strobe edges discarded during preset
    din = 4'd5; load_n = 1'b0;
    pulse_up();
    load_n = 1'b1; wait_neg(3);
    chk("R2 preset holds over up strobe", q_dec, 5);
    chk("R2 no late count after preset", q_bin, 5);

    // R1 clear beats preset
    din = 4'd3; load_n = 1'b0; clr = 1'b1; wait_neg(1);
    clr = 1'b0; load_n = 1'b1; wait_neg(1);
    chk("R1 clear beats preset", q_dec, 0);

    // R9 both strobes rising together
    do_load(4'd4);
    cnt_up = 1'b0; cnt_dn = 1'b0; wait_neg(3);
    cnt_up = 1'b1; cnt_dn = 1'b1; wait_neg(4);
    chk("R9 simultaneous rise ignored", q_dec, 4);

    // R9 up strobe while down held low, then R4 on release of down
    cnt_dn = 1'b0; wait_neg(3);
    pulse_up();
    chk("R9 up ignored while down low", q_dec, 4);
    cnt_dn = 1'b1; wait_neg(3);
    chk("R4 down counts on release", q_dec, 3);
    chk("R4 binary down counts", q_bin, 3);

    // R10 two-stage chain
    do_load(4'd9);
    pulse_up(); wait_neg(4);
    chk("R10 low stage wrapped", q_lo, 0);
    chk("R10 high stage stepped up", q_hi, 0);
    pulse_dn(); wait_neg(4);
    chk("R10 low stage wrapped down", q_lo, 9);
    chk("R10 high stage stepped down", q_hi, 9);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule